// File: doc/BRIEF.md
# Chained Serial Converter Write Controller

This block is a host-side master that updates a whole daisy chain of 14-bit serial-input converters in one transaction. A single start request carries one code for every device in the chain. The block widens each code to a 16-bit word by appending two zero filler bits. It then shifts the words out on a serial clock, a data line and an active-low select/load strobe. All three lines are generated from the system clock.

The devices pass bits from one to the next through their shift registers. For that reason, the word for the device farthest from the host leaves first and the word for the nearest device leaves last. After N×16 clock pulses, every device therefore holds its own word. The select line then returns high once, and all devices update their outputs at the same instant.

Every timing interval is a nanosecond minimum, given as a parameter. The block turns each one into a whole number of system-clock cycles, rounding up. A `busy` level and a one-cycle `done` pulse frame each transaction.

Top module: `dac_chain_writer`

## Requirements
- R1: After reset, `cs_n` is 1, `sclk` is 0, `busy` is 0 and `done` is 0.
- R2: Each device receives a 16-bit word: its 14-bit code, most significant bit first, followed by two filler bits driven as 0.
- R3: Device k takes its code from `codes[k*14 +: 14]`, where device 0 is the nearest to the host. The word for device N-1 is sent first and the word for device 0 is sent last.
- R4: A transaction produces exactly N×16 rising edges on `sclk`, and `cs_n` stays low from before the first edge until after the last edge.
- R5: `sclk` is low both in the cycle before `cs_n` falls and in the cycle it falls. The first rising edge of `sclk` comes at least max(ceil(20 ns), ceil(40 ns)) cycles after `cs_n` falls; at 50 MHz this is 2 cycles.
- R6: Each high phase and each low phase of `sclk` within a transaction lasts at least ceil(40 ns) cycles, which is 2 cycles at 50 MHz.
- R7: `sdata` never changes while `sclk` stays high. It holds its value for at least ceil(40 ns) cycles before every rising edge.
- R8: `cs_n` rises at least ceil(40 ns) cycles after the last rising edge of `sclk`. `cs_n` then stays high for at least ceil(50 ns) cycles (3 cycles at 50 MHz) before `busy` falls.
- R9: A `start` pulse that arrives while `busy` is 1 is ignored. No second transaction follows, and the data being sent is not altered.
- R10: `busy` is 1 from the cycle after `start` is accepted until the select-high interval ends. `done` is 1 for exactly one cycle, in the first cycle in which `busy` is 0 again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request pulse; accepted only when idle |
| codes | input | N_DEV*14 | Packed codes, device 0 in the low bits |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle pulse when a transaction ends |
| sclk | output | 1 | Serial clock to the chain |
| sdata | output | 1 | Serial data to the first device in the chain |
| cs_n | output | 1 | Active-low select; its rising edge loads all devices |

## Verification
The embedded properties assume that `start` is synchronous to `clk`. They also assume that `codes` needs to be valid only in the cycle in which `start` is accepted, because the frame is captured then.

The bench drives `start` and `codes` a quarter period after a rising edge, so both are always stable at the capturing edge. It changes `codes` and re-pulses `start` in the middle of a transfer to show that the captured frame is unaffected. A monitor samples the serial lines on every falling system-clock edge and measures each interval in whole cycles.

// File: rtl/dcw_pkg.sv
package dcw_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEAD,
        ST_HIGH,
        ST_LOW,
        ST_TAIL,
        ST_GAP
    } dcw_state_e;

    // Whole system-clock cycles covering a nanosecond minimum, never zero.
    function automatic int unsigned ns2cyc(input int unsigned ns, input int unsigned per);
        int unsigned c;
        c = (ns + per - 1) / per;
        return (c == 0) ? 1 : c;
    endfunction

    function automatic int unsigned umax(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/dcw_packer.sv
module dcw_packer #(
    parameter int unsigned N_DEV  = 3,
    parameter int unsigned CODE_W = 14,
    parameter int unsigned WORD_W = 16
) (
    input  logic [N_DEV*CODE_W-1:0] codes,
    output logic [N_DEV*WORD_W-1:0] frame
);
    localparam int unsigned PAD_W = WORD_W - CODE_W;

    // Device g lands in word slot g; the top slot (farthest device) leaves first.
    for (genvar g = 0; g < N_DEV; g++) begin : g_word
        assign frame[g*WORD_W +: WORD_W] = {codes[g*CODE_W +: CODE_W], {PAD_W{1'b0}}};
    end
endmodule

// File: rtl/dcw_shifter.sv
module dcw_shifter #(
    parameter int unsigned W = 48
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         shift,
    input  logic [W-1:0] load_val,
    output logic         msb
);
    logic [W-1:0] sr_d, sr_q;

    always_comb begin
        sr_d = sr_q;
        if (load)
            sr_d = load_val;
        else if (shift)
            sr_d = {sr_q[W-2:0], 1'b0};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            sr_q <= '0;
        else
            sr_q <= sr_d;
    end

    assign msb = sr_q[W-1];

    AST_LOAD_NOT_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        !(load && shift));  // R9
endmodule

// File: rtl/dac_chain_writer.sv
module dac_chain_writer
    import dcw_pkg::*;
#(
    parameter int unsigned N_DEV         = 3,
    parameter int unsigned CODE_W        = 14,
    parameter int unsigned WORD_W        = 16,
    parameter int unsigned CLK_PERIOD_NS = 20,
    parameter int unsigned SETUP_NS      = 40,
    parameter int unsigned HIGH_NS       = 40,
    parameter int unsigned LOW_NS        = 40,
    parameter int unsigned CS_LEAD_NS    = 20,
    parameter int unsigned CS_TAIL_NS    = 40,
    parameter int unsigned CS_GAP_NS     = 50
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic [N_DEV*CODE_W-1:0] codes,
    output logic                    busy,
    output logic                    done,
    output logic                    sclk,
    output logic                    sdata,
    output logic                    cs_n
);
    localparam int unsigned TOTAL  = N_DEV * WORD_W;
    localparam int unsigned SU_C   = ns2cyc(SETUP_NS, CLK_PERIOD_NS);
    localparam int unsigned LEAD_C = umax(ns2cyc(CS_LEAD_NS, CLK_PERIOD_NS), SU_C);
    localparam int unsigned HIGH_C = ns2cyc(HIGH_NS, CLK_PERIOD_NS);
    localparam int unsigned LOW_C  = umax(ns2cyc(LOW_NS, CLK_PERIOD_NS), SU_C);
    localparam int unsigned TAIL_C = ns2cyc(CS_TAIL_NS, CLK_PERIOD_NS);
    localparam int unsigned GAP_C  = ns2cyc(CS_GAP_NS, CLK_PERIOD_NS);
    localparam int unsigned MAX_C  = umax(umax(LEAD_C, HIGH_C), umax(umax(LOW_C, TAIL_C), GAP_C));
    localparam int unsigned CNT_W  = $clog2(MAX_C + 1);
    localparam int unsigned BIT_W  = $clog2(TOTAL + 1);

    localparam logic [CNT_W-1:0] LEAD_M1 = CNT_W'(LEAD_C - 1);
    localparam logic [CNT_W-1:0] HIGH_M1 = CNT_W'(HIGH_C - 1);
    localparam logic [CNT_W-1:0] LOW_M1  = CNT_W'(LOW_C - 1);
    localparam logic [CNT_W-1:0] TAIL_M1 = CNT_W'(TAIL_C - 1);
    localparam logic [CNT_W-1:0] GAP_M1  = CNT_W'(GAP_C - 1);
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(TOTAL - 1);

    typedef struct packed {
        dcw_state_e       st;
        logic [CNT_W-1:0] cnt;
        logic [BIT_W-1:0] left;
        logic             sclk;
        logic             cs_n;
        logic             done;
    } ctl_t;

    localparam ctl_t CTL_RST = '{st: ST_IDLE, cnt: '0, left: '0, sclk: 1'b0, cs_n: 1'b1, done: 1'b0};

    ctl_t              ctl_d, ctl_q;
    logic              load, shift;
    logic [TOTAL-1:0]  frame;

    dcw_packer #(.N_DEV(N_DEV), .CODE_W(CODE_W), .WORD_W(WORD_W)) u_pack (
        .codes (codes),
        .frame (frame)
    );

    dcw_shifter #(.W(TOTAL)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .shift    (shift),
        .load_val (frame),
        .msb      (sdata)
    );

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.done = 1'b0;
        load       = 1'b0;
        shift      = 1'b0;
        if (ctl_q.cnt != '0)
            ctl_d.cnt = ctl_q.cnt - 1'b1;
        unique case (ctl_q.st)
            ST_IDLE: begin
                if (start) begin
                    ctl_d.st   = ST_LEAD;
                    ctl_d.cnt  = LEAD_M1;
                    ctl_d.cs_n = 1'b0;
                    ctl_d.sclk = 1'b0;
                    ctl_d.left = LAST_BIT;
                    load       = 1'b1;
                end
            end
            ST_LEAD: begin
                if (ctl_q.cnt == '0) begin
                    ctl_d.st   = ST_HIGH;
                    ctl_d.sclk = 1'b1;
                    ctl_d.cnt  = HIGH_M1;
                end
            end
            ST_HIGH: begin
                if (ctl_q.cnt == '0) begin
                    ctl_d.sclk = 1'b0;
                    if (ctl_q.left == '0) begin
                        ctl_d.st  = ST_TAIL;
                        ctl_d.cnt = TAIL_M1;
                    end else begin
                        ctl_d.st   = ST_LOW;
                        ctl_d.cnt  = LOW_M1;
                        ctl_d.left = ctl_q.left - 1'b1;
                        shift      = 1'b1;
                    end
                end
            end
            ST_LOW: begin
                if (ctl_q.cnt == '0) begin
                    ctl_d.st   = ST_HIGH;
                    ctl_d.sclk = 1'b1;
                    ctl_d.cnt  = HIGH_M1;
                end
            end
            ST_TAIL: begin
                if (ctl_q.cnt == '0) begin
                    ctl_d.st   = ST_GAP;
                    ctl_d.cs_n = 1'b1;
                    ctl_d.cnt  = GAP_M1;
                end
            end
            ST_GAP: begin
                if (ctl_q.cnt == '0) begin
                    ctl_d.st   = ST_IDLE;
                    ctl_d.done = 1'b1;
                end
            end
            default: ctl_d = CTL_RST;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            ctl_q <= CTL_RST;
        else
            ctl_q <= ctl_d;
    end

    assign busy = (ctl_q.st != ST_IDLE);
    assign done = ctl_q.done;
    assign sclk = ctl_q.sclk;
    assign cs_n = ctl_q.cs_n;

    AST_SCLK_LOW_AT_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n) |-> (!sclk && !$past(sclk)));  // R5
    AST_SCLK_INSIDE_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        sclk |-> !cs_n);  // R4
    AST_DATA_STILL_WHILE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk && $past(sclk)) |-> $stable(sdata));  // R7
    AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));  // R10
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);  // R10
    AST_RELEASE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n) |-> busy);  // R8
    AST_HIGH_MIN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sclk) |=> sclk);  // R6
endmodule

// File: tb/sim_dac_chain_writer.sv
module sim_dac_chain_writer;
    localparam int N  = 3;
    localparam int CW = 14;
    localparam int TOT = N * 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [N*CW-1:0] codes = '0;
    logic busy, done, sclk, sdata, cs_n;

    int n_tests = 0;
    int n_fail  = 0;

    always #10 clk = ~clk;

    dac_chain_writer #(.N_DEV(N)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .codes(codes),
        .busy(busy), .done(done), .sclk(sclk), .sdata(sdata), .cs_n(cs_n)
    );

    // Line monitor, sampled on falling clk edges; all intervals in cycles.
    logic         p_sclk = 1'b0, p_cs = 1'b1, p_sd = 1'b0;
    logic [127:0] m_stream;
    int m_rises, m_lead, m_min_hi, m_min_lo, m_min_su, m_tail, m_gap;
    int m_hi_run, m_lo_run, m_since_chg, m_since_rise, m_chg_high, m_done_cnt;
    logic m_bad_cs_fall;

    always @(negedge clk) begin
        if (!rst_n) begin
            m_done_cnt = 0;
            m_stream = '0; m_rises = 0;
        end else begin
            if (p_cs && !cs_n) begin
                m_bad_cs_fall = sclk | p_sclk;
                m_stream = '0; m_rises = 0; m_lead = 0; m_min_hi = 999;
                m_min_lo = 999; m_min_su = 999; m_tail = 0; m_chg_high = 0;
                m_lo_run = 0; m_hi_run = 0; m_since_rise = 0;
            end
            if (sdata != p_sd) m_since_chg = 0; else m_since_chg = m_since_chg + 1;
            if (!cs_n) begin
                if (sclk && p_sclk && (sdata != p_sd)) m_chg_high++;
                if (sclk && !p_sclk) begin
                    m_rises++;
                    m_stream = {m_stream[126:0], sdata};
                    if (m_since_chg < m_min_su) m_min_su = m_since_chg;
                    if (m_rises == 1) m_lead = m_lo_run;
                    else if (m_lo_run < m_min_lo) m_min_lo = m_lo_run;
                    m_lo_run = 0; m_since_rise = 0;
                end else begin
                    m_since_rise++;
                end
                if (!sclk && p_sclk && (m_hi_run < m_min_hi)) m_min_hi = m_hi_run;
                if (sclk) begin m_hi_run++; end else begin if (p_sclk) m_hi_run = 0; m_lo_run++; end
            end
            if (!p_cs && cs_n) begin
                m_tail = m_since_rise + 1;
                m_gap = 0;
            end
            if (cs_n && busy) m_gap++;
            if (done) m_done_cnt++;
        end
        p_sclk = sclk; p_cs = cs_n; p_sd = sdata;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk); #5;
    endtask

    function automatic logic [127:0] exp_frame(input logic [N*CW-1:0] c);
        logic [127:0] f = '0;
        for (int d = N - 1; d >= 0; d--)
            f = (f << 16) | {112'b0, c[d*CW +: CW], 2'b00};
        return f;
    endfunction

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) step();
        chk(cs_n == 1'b1, "R1", "cs_n idle", cs_n, 1);
        chk(sclk == 1'b0, "R1", "sclk idle", sclk, 0);
        chk(busy == 1'b0 && done == 1'b0, "R1", "busy/done idle", {busy, done}, 0);
        rst_n = 1'b1;
        repeat (2) step();
    endtask

    task automatic t_xfer(input logic [N*CW-1:0] c, input bit poke);
        int waited = 0;
        int d0 = m_done_cnt;
        codes = c; start = 1'b1;
        step();
        start = 1'b0;
        chk(busy == 1'b1, "R10", "busy after start", busy, 1);
        if (poke) begin
            repeat (20) step();
            codes = ~c; start = 1'b1;
            step();
            start = 1'b0;
        end
        while (!done && waited < 2000) begin step(); waited++; end
        chk(done == 1'b1, "R10", "done seen", done, 1);
        chk(busy == 1'b0, "R10", "busy low with done", busy, 0);
        #10;
        chk(m_stream[TOT-1:0] == exp_frame(c), "R2 R3", "shifted frame", m_stream, exp_frame(c));
        chk(m_rises == TOT, "R4", "rising edge count", m_rises, TOT);
        chk(m_bad_cs_fall == 1'b0, "R5", "sclk low at select", m_bad_cs_fall, 0);
        chk(m_lead >= 2, "R5", "select to first edge", m_lead, 2);
        chk(m_min_hi >= 2 && m_min_lo >= 2, "R6", "min high/low", {m_min_hi, m_min_lo}, {32'd2, 32'd2});
        chk(m_chg_high == 0 && m_min_su >= 2, "R7", "data hold/setup", {m_chg_high, m_min_su}, {32'd0, 32'd2});
        chk(m_tail >= 2, "R8", "last edge to release", m_tail, 2);
        chk(m_gap >= 3, "R8", "release high time", m_gap, 3);
        step();
        chk(done == 1'b0 && m_done_cnt == d0 + 1, "R10", "done one cycle", {done, m_done_cnt - d0}, 1);
        if (poke) begin
            repeat (10) step();
            chk(busy == 1'b0 && cs_n == 1'b1, "R9", "no second transfer", {busy, cs_n}, 1);
        end
    endtask

    initial begin
        t_reset();
        t_xfer({14'h3FFF, 14'h0000, 14'h2AAA}, 1'b0);
        t_xfer({14'h0001, 14'h2000, 14'h1555}, 1'b0);
        t_xfer({14'h1234, 14'h0F0F, 14'h3C3C}, 1'b1);
        t_xfer('0, 1'b0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(20 * 200000);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule